// File: doc/BRIEF.md
# Two-Channel Late-Parity Checker with Latency Modes

This block checks the parity of registered data words against a parity bit that the controller sends some cycles after the data itself. It has two independent channels. Each channel watches its own 14-bit slice of the data input and has its own parity input. Each channel leaves three fixed bit positions out of the parity sum.

For every checked word, a channel produces a partial-parity bit and an active-low error flag. Once the error flag drops, it stays low for two cycles.

A mode input sets how late the parity bit arrives relative to its data:
- **Standalone** (`cascade` = 0): the parity bit arrives one cycle after its data.
- **Cascaded** (`cascade` = 1): the parity bit arrives two cycles after its data.

The data is delayed inside the block by the same amount, so that each word meets its own parity bit.

Two active-low select inputs gate the outputs. When both selects are high, every output holds its value. A synchronous active-high reset takes priority over the gating.

Top module: `late_parity_checker`

## Requirements
- R1: The partial-parity output of a channel equals the XOR of the channel's checked data bits and the parity bit that belongs to that word.
- R2: When a channel is not in an error hold, its error flag `err_n` is 0 if the partial-parity result is 1 and 1 if it is 0. Whenever `err_n` is 1, the partial-parity output of that channel is 0.
- R3: Bit positions 0, 3 and 6 of each channel's 14-bit slice are left out of the parity sum. Flipping one of them never raises an error. Flipping any other bit of the slice does.
- R4: Channel k checks `d_in[k*14 +: 14]` against `par_in[k]` and drives `ppo[k]` and `err_n[k]`. A fault on one channel never disturbs the other channel.
- R5: With `cascade` = 0, the parity bit for the word sampled at clock edge t is sampled at edge t+1. The outputs for that word change at edge t+2.
- R6: With `cascade` = 1, the parity bit for the word sampled at edge t is sampled at edge t+2. The outputs for that word change at edge t+3.
- R7: An error flag that goes low at one edge stays low through the next ungated edge, whatever that edge evaluates. On that edge the partial-parity output still updates.
- R8: At an edge where both `sel_a_n` and `sel_b_n` are 1, `ppo` and `err_n` (and the error hold) keep their values. If either select is 0, the outputs update normally.
- R9: While `rst` is 1, each edge sets `ppo` to 0, sets `err_n` to all ones and clears the data pipeline, whatever the select inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade | input | 1 | 0 = parity bit one cycle late, 1 = two cycles late |
| sel_a_n | input | 1 | First active-low select |
| sel_b_n | input | 1 | Second active-low select; outputs hold when both selects are 1 |
| d_in | input | 28 | Data words, 14 bits per channel |
| par_in | input | 2 | Late parity bit, one per channel |
| ppo | output | 2 | Partial-parity output per channel |
| err_n | output | 2 | Active-low sticky parity error flag per channel |

## Verification
Two functions can fall on the same edge: the two-cycle error hold, and a fresh evaluation of a clean word. The partial-parity bit must then return to 0 while the flag stays low.

The bench provokes this as follows:
1. It injects a single parity fault.
2. It sends only clean words after the fault.
3. It checks, on the edge after the flag drops, that `ppo` is 0 and `err_n` is still 0.
4. It checks that the flag returns high one edge later.

A behavioural reference model, stepped on every clock, judges the same overlap under random faults, random gating and mode changes.

// File: rtl/late_parity_pkg.sv
`timescale 1ns/1ps
package late_parity_pkg;

    localparam int LP_CHANNELS = 2;
    localparam int LP_WORD_W   = 14;
    localparam int LP_MAX_LAG  = 2;

    // Positions that do not take part in the parity sum.
    localparam logic [LP_WORD_W-1:0] LP_SKIP_MASK = 14'b00_0000_0100_1001;

    typedef enum logic {
        LAG_SOLO    = 1'b0,
        LAG_CASCADE = 1'b1
    } lag_mode_e;

    typedef struct packed {
        logic ppo;
        logic err_n;
        logic hold;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{ppo: 1'b0, err_n: 1'b1, hold: 1'b0};

endpackage

// File: rtl/lp_align.sv
`timescale 1ns/1ps
module lp_align
    import late_parity_pkg::*;
#(
    parameter int WORD_W  = LP_WORD_W,
    parameter int MAX_LAG = LP_MAX_LAG
) (
    input  logic              clk,
    input  logic              rst,
    input  lag_mode_e         mode,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    localparam int SEL_W = (MAX_LAG > 1) ? $clog2(MAX_LAG) : 1;

    logic [MAX_LAG-1:0][WORD_W-1:0] taps;
    logic [SEL_W-1:0]               tap_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps[0] <= din;
            for (int s = 1; s < MAX_LAG; s++) begin
                taps[s] <= taps[s-1];
            end
        end
    end

    always_comb begin
        tap_sel = (mode == LAG_CASCADE) ? SEL_W'(MAX_LAG - 1) : '0;
        dout    = taps[tap_sel];
    end

endmodule

// File: rtl/lp_eval.sv
`timescale 1ns/1ps
module lp_eval
    import late_parity_pkg::*;
#(
    parameter int                WORD_W = LP_WORD_W,
    parameter logic [WORD_W-1:0] SKIP   = LP_SKIP_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              par,
    output logic              stage
);

    logic word_par;

    always_comb begin
        word_par = ^(word & ~SKIP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= 1'b0;
        end else begin
            stage <= word_par ^ par;
        end
    end

endmodule

// File: rtl/lp_flag.sv
`timescale 1ns/1ps
module lp_flag
    import late_parity_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        gate,
    input  logic        stage,
    output flag_state_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FLAG_RESET;
        end else if (!gate) begin
            st.ppo <= stage;
            if (st.hold) begin
                st.err_n <= 1'b0;
                st.hold  <= 1'b0;
            end else begin
                st.err_n <= ~stage;
                st.hold  <= stage;
            end
        end
    end

endmodule

// File: rtl/late_parity_checker.sv
`timescale 1ns/1ps
module late_parity_checker
    import late_parity_pkg::*;
#(
    parameter int                CH      = LP_CHANNELS,
    parameter int                WORD_W  = LP_WORD_W,
    parameter int                MAX_LAG = LP_MAX_LAG,
    parameter logic [WORD_W-1:0] SKIP    = LP_SKIP_MASK
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cascade,
    input  logic                 sel_a_n,
    input  logic                 sel_b_n,
    input  logic [CH*WORD_W-1:0] d_in,
    input  logic [CH-1:0]        par_in,
    output logic [CH-1:0]        ppo,
    output logic [CH-1:0]        err_n
);

    lag_mode_e mode;
    logic      gate;

    always_comb begin
        mode = lag_mode_e'(cascade);
        gate = sel_a_n & sel_b_n;
    end

    for (genvar c = 0; c < CH; c++) begin : g_chan
        logic [WORD_W-1:0] aligned;
        logic              stage;
        flag_state_t       st;

        lp_align #(.WORD_W(WORD_W), .MAX_LAG(MAX_LAG)) u_align (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .din  (d_in[c*WORD_W +: WORD_W]),
            .dout (aligned)
        );

        lp_eval #(.WORD_W(WORD_W), .SKIP(SKIP)) u_eval (
            .clk   (clk),
            .rst   (rst),
            .word  (aligned),
            .par   (par_in[c]),
            .stage (stage)
        );

        lp_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .gate  (gate),
            .stage (stage),
            .st    (st)
        );

        assign ppo[c]   = st.ppo;
        assign err_n[c] = st.err_n;
    end

endmodule

// File: rtl/late_parity_checker_sva.sv
`timescale 1ns/1ps
module late_parity_checker_sva #(
    parameter int CH = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          sel_a_n,
    input logic          sel_b_n,
    input logic [CH-1:0] ppo,
    input logic [CH-1:0] err_n
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R9: an edge taken in reset leaves outputs at their reset values
    always @(negedge clk) begin
        if (rst_q == 1'b1) begin
            p_reset_state_r9: assert (ppo == '0 && err_n == '1)
                else $error("reset state violated");
        end
    end

    // R8: both selects high freezes every output
    p_gate_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_a_n && sel_b_n) |=> ($stable(ppo) && $stable(err_n)));

    for (genvar c = 0; c < CH; c++) begin : g_chk
        // R7: a freshly dropped flag is still low one edge later
        p_err_two_cycle_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(err_n[c]) |=> !err_n[c]);

        // R2: a clean flag never coexists with a set partial-parity bit
        p_clean_ppo_low_r2: assert property (@(posedge clk) disable iff (rst)
            err_n[c] |-> !ppo[c]);
    end

endmodule

bind late_parity_checker late_parity_checker_sva #(.CH(CH)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .sel_a_n (sel_a_n),
    .sel_b_n (sel_b_n),
    .ppo     (ppo),
    .err_n   (err_n)
);

// File: tb/late_parity_checker_bench.sv
`timescale 1ns/1ps
module late_parity_checker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cascade;
    logic        sel_a_n;
    logic        sel_b_n;
    logic [27:0] d_in;
    logic [1:0]  par_in;
    logic [1:0]  ppo;
    logic [1:0]  err_n;

    int    checks   = 0;
    int    failures = 0;
    bit    done     = 0;
    string tag      = "R9";

    // reference model state
    logic [1:0]  m_stage, m_ppo, m_err, m_hold;
    logic [27:0] h1, h2;
    logic [1:0]  pq1, pq2;

    always #10 clk = ~clk;

    late_parity_checker u_late_parity_checker (
        .clk     (clk),
        .rst     (rst),
        .cascade (cascade),
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .d_in    (d_in),
        .par_in  (par_in),
        .ppo     (ppo),
        .err_n   (err_n)
    );

    function automatic logic refpar(input logic [13:0] w);
        logic p = 1'b0;
        for (int i = 0; i < 14; i++) begin
            if (i != 0 && i != 3 && i != 6) p = p ^ w[i];
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [1:0]  old;
        logic [27:0] src;
        if (rst) begin
            m_stage = '0; m_ppo = '0; m_err = 2'b11; m_hold = '0;
            h1 = '0; h2 = '0;
        end else begin
            old = m_stage;
            src = cascade ? h2 : h1;
            for (int c = 0; c < 2; c++) begin
                m_stage[c] = refpar(src[c*14 +: 14]) ^ par_in[c];
            end
            if (!(sel_a_n && sel_b_n)) begin
                for (int c = 0; c < 2; c++) begin
                    m_ppo[c] = old[c];
                    if (m_hold[c]) begin
                        m_err[c] = 1'b0;
                        m_hold[c] = 1'b0;
                    end else begin
                        m_err[c] = ~old[c];
                        m_hold[c] = old[c];
                    end
                end
            end
            h2 = h1;
            h1 = d_in;
        end
    endtask

    // One clock: drive, let the edge happen, update model, compare.
    task automatic step(input logic [27:0] d, input logic [27:0] flip,
                        input logic [1:0] inj);
        logic [1:0] good;
        good   = cascade ? pq2 : pq1;
        d_in   = d ^ flip;
        par_in = good ^ inj;
        pq2    = pq1;
        pq1    = {refpar(d[27:14]), refpar(d[13:0])};
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(ppo === m_ppo && err_n === m_err, tag,
              {4'h0, ppo, err_n}, {4'h0, m_ppo, m_err});
    endtask

    task automatic clean(input int n);
        for (int i = 0; i < n; i++) step(28'($urandom()), '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cascade = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0;
        d_in = '0; par_in = '0; pq1 = '0; pq2 = '0;
        @(negedge clk);
        tag = "R9 reset";
        for (int i = 0; i < 3; i++) step(28'($urandom()), '0, 2'b11);
        check(ppo == 2'b00 && err_n == 2'b11, "R9 reset values", {6'h0, ppo}, 8'h0);
        rst = 1'b0; pq1 = '0; pq2 = '0;

        // clean standalone traffic
        tag = "R1 R5 clean standalone";
        clean(20);
        check(err_n == 2'b11 && ppo == 2'b00, "R1 clean words", {4'h0, ppo, err_n}, 8'h03);

        // parity fault on channel 0: latency, channel isolation and hold
        tag = "R5 R7 fault standalone";
        step(28'($urandom()), '0, 2'b01);
        check(err_n == 2'b11, "R5 no change one edge after parity", {6'h0, err_n}, 8'h03);
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b10, "R4 R5 flag drops on channel 0 only", {6'h0, err_n}, 8'h02);
        check(ppo == 2'b01, "R2 ppo set with flag", {6'h0, ppo}, 8'h01);
        step(28'($urandom()), '0, '0);
        check(err_n[0] == 1'b0, "R7 flag held second cycle", {7'h0, err_n[0]}, 8'h00);
        check(ppo[0] == 1'b0, "R7 ppo updates during hold", {7'h0, ppo[0]}, 8'h00);
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b11, "R7 flag releases", {6'h0, err_n}, 8'h03);

        // excluded and counted data bit flips
        tag = "R3 bit flips";
        step(28'($urandom()), 28'h1 << 17, '0);
        clean(2);
        check(err_n == 2'b11 && ppo == 2'b00, "R3 excluded bit ignored", {4'h0, ppo, err_n}, 8'h03);
        step(28'($urandom()), 28'h1 << 16, '0);
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b11, "R3 counted flip not yet visible", {6'h0, err_n}, 8'h03);
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b01, "R3 R4 counted flip flags channel 1", {6'h0, err_n}, 8'h01);
        clean(3);

        // cascaded mode
        tag = "R6 cascade";
        cascade = 1'b1;
        clean(6);
        check(err_n == 2'b11, "R6 settled clean", {6'h0, err_n}, 8'h03);
        step(28'($urandom()), 28'h1 << 5, '0);
        step(28'($urandom()), '0, '0);
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b11, "R6 not visible at edge t+2", {6'h0, err_n}, 8'h03);
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b10, "R6 visible at edge t+3", {6'h0, err_n}, 8'h02);
        clean(3);
        check(err_n == 2'b11, "R7 cascade release", {6'h0, err_n}, 8'h03);

        // gating
        tag = "R8 gating";
        cascade = 1'b0;
        clean(5);
        sel_a_n = 1'b1; sel_b_n = 1'b1;
        for (int i = 0; i < 4; i++) step(28'($urandom()), '0, 2'b11);
        check(err_n == 2'b11 && ppo == 2'b00, "R8 outputs frozen", {4'h0, ppo, err_n}, 8'h03);
        sel_b_n = 1'b0;
        step(28'($urandom()), '0, '0);
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b00, "R8 one select low updates", {6'h0, err_n}, 8'h00);
        sel_b_n = 1'b1;
        step(28'($urandom()), '0, '0);
        check(err_n == 2'b00, "R8 held while gated", {6'h0, err_n}, 8'h00);
        rst = 1'b1;
        step(28'($urandom()), '0, 2'b11);
        check(err_n == 2'b11 && ppo == 2'b00, "R9 reset beats gating", {4'h0, ppo, err_n}, 8'h03);
        rst = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0; pq1 = '0; pq2 = '0;

        // random stress against the model
        tag = "R1 R2 R4 R7 R8 random";
        for (int i = 0; i < 600; i++) begin
            if (($urandom() % 40) == 0) cascade = ~cascade;
            sel_a_n = (($urandom() % 4) == 0);
            sel_b_n = (($urandom() % 3) == 0);
            rst     = (($urandom() % 150) == 0);
            step(28'($urandom()),
                 (($urandom() % 6) == 0) ? (28'h1 << ($urandom() % 28)) : 28'h0,
                 (($urandom() % 8) == 0) ? 2'($urandom()) : 2'b00);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule